// File: doc/BRIEF.md
# Command-Response Buffer Register Interface

This block is the register face of a security coprocessor that is driven through a command-response buffer. A host sees a small set of 32-bit control registers and a byte-addressed data window over one simple bus. The control registers cover locality ownership, idle and ready control, and two doorbells: start and cancel. The host claims the locality, wakes the engine, loads a command into the data window and rings the start doorbell. The block then offers the command to a backend with its byte length. The backend runs it, writes the response bytes back into the same window, and reports completion with a result code. The host then reads the response out of the window.

Each bus access is one cycle of `bus_req`, with `bus_we` selecting write or read and `bus_len` giving the byte count (1 to 8). Address bits [11:0] select the offset and bits [15:12] carry the requester locality. Read data comes back one cycle later with `bus_rvalid`. The command offer is a valid/ready stream. `cmd_valid` stays high, with `cmd_len` held steady, until the backend takes it with `cmd_ready`, so the backend may stall for as long as it needs. Completion (`done_valid`), response byte writes (`rsp_we`) and the cancel request (`cmd_cancel`) are plain single-cycle strobes with no back-pressure.

Top module: `crb_regif`

## Requirements
- R1: After reset the registers read as follows. Locality state (0x00) reads 0x80: register-valid is bit 7, locality-assigned is bit 1 and the active locality (bits 4:2) is 0. Control status (0x44) reads 0x2, with idle in bit 1 and error in bit 0. Interface ID (0x30) reads 0x00025811. Interface ID2 (0x34) reads 0x00001014. Command size (0x58) and response size (0x64) read WIN_SIZE-0x80. Command address low (0x5C) and response address (0x68) read WIN_BASE+0x80. Command address high (0x60) reads 0.
- R2: Locality control (0x08) acts on the value written. A value of 1 sets locality-assigned and granted (locality status 0x0C bit 0) and clears been-seized (0x0C bit 1). A value of 2 clears locality-assigned and granted. A value of 8 changes nothing and raises no error. Any other value changes nothing and pulses `bus_err`.
- R3: Control request (0x40) acts on the value written. A value of 1 clears idle and a value of 2 sets idle. Any other value leaves idle unchanged and pulses `bus_err`.
- R4: A write of 1 to start (0x4C) is taken only when three things hold: the start bit (0x4C bit 0) is clear, locality-assigned is set, and address bits [15:12] equal the active locality. While nothing is assigned, the active locality compares as 0xFF. When the write is taken, the start bit is set.
- R5: When a start is taken, `cmd_valid` rises on the next cycle with `cmd_len` equal to the buffer length counter. Both stay unchanged until the first cycle in which `cmd_ready` is high.
- R6: A write of 1 to cancel (0x48) pulses `cmd_cancel` for one cycle only if the start bit is set. Otherwise it has no effect.
- R7: `done_valid` while the start bit is set clears the start bit. If `done_code` is nonzero it also sets the error bit, which then holds until reset.
- R8: A bus write at offset 0x80+n (n >= 0) with n+len <= BUF_BYTES stores `bus_wdata` bytes little-endian at buffer bytes n to n+len-1. A write with n = 0 first zeroes the whole buffer and restarts the length counter at len. Any other write adds len to the counter. A buffer write that does not fit changes nothing and pulses `bus_err`.
- R9: A bus read at 0x80+n that fits returns buffer bytes n to n+len-1 little-endian, with all higher bytes zero. A byte written through `rsp_we` at index `rsp_idx` can be read back this way.
- R10: A register write with len > 4 pulses `bus_err` and changes nothing. The one exception is an 8-byte write to 0x68: it stores the low 32 bits and raises no error. A register read with len > 4 returns 0.
- R11: Locality state bit 0 reads 1 whenever `est_flag` is low, and 0 whenever it is high.
- R12: A register write to any offset other than 0x08, 0x40, 0x48, 0x4C, 0x58, 0x5C, 0x60, 0x64 or 0x68 pulses `bus_err` and changes no state. A read of an unmapped offset, or of 0x08, 0x40 or 0x48, returns 0.
- R13: Every read request produces `bus_rvalid` with its data on the following cycle. `bus_err` pulses only in the cycle after a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | [15:12] locality, [11:0] offset |
| bus_len | input | 4 | Byte count, 1 to 8 |
| bus_wdata | input | 64 | Write data, little-endian |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Read data |
| bus_err | output | 1 | One-cycle pulse for a rejected write |
| cmd_valid | output | 1 | Command offered to the backend |
| cmd_ready | input | 1 | Backend accepts the command |
| cmd_len | output | LEN_W | Command byte length |
| cmd_cancel | output | 1 | One-cycle cancel request |
| done_valid | input | 1 | Command complete |
| done_code | input | 32 | Result code, 0 = success |
| est_flag | input | 1 | Backend established flag |
| rsp_we | input | 1 | Backend response byte write |
| rsp_idx | input | $clog2(BUF_BYTES) | Response byte index |
| rsp_byte | input | 8 | Response byte |

## Verification
A corrupted locality, idle or start bit shows up on the very next read of 0x00, 0x0C, 0x44 or 0x4C. A wrong start bit also shows on the next start or cancel write, as a missing or extra pulse on `cmd_valid` or `cmd_cancel`. A buffer length counter that drifts cannot be seen until the next start is taken, where `cmd_len` carries the wrong value. For that reason the random mix issues starts often, between runs of buffer writes that sometimes land on byte 0.

// File: rtl/crb_pkg.sv
package crb_pkg;
  // register offsets (low 8 bits of the access address)
  localparam logic [7:0] OFF_LOC_STATE = 8'h00;
  localparam logic [7:0] OFF_LOC_CTRL  = 8'h08;
  localparam logic [7:0] OFF_LOC_STS   = 8'h0C;
  localparam logic [7:0] OFF_ID        = 8'h30;
  localparam logic [7:0] OFF_ID2       = 8'h34;
  localparam logic [7:0] OFF_REQ       = 8'h40;
  localparam logic [7:0] OFF_STS       = 8'h44;
  localparam logic [7:0] OFF_CANCEL    = 8'h48;
  localparam logic [7:0] OFF_START     = 8'h4C;
  localparam logic [7:0] OFF_CMD_SIZE  = 8'h58;
  localparam logic [7:0] OFF_CMD_LO    = 8'h5C;
  localparam logic [7:0] OFF_CMD_HI    = 8'h60;
  localparam logic [7:0] OFF_RSP_SIZE  = 8'h64;
  localparam logic [7:0] OFF_RSP_ADDR  = 8'h68;
  localparam logic [11:0] BUF_BASE     = 12'h080;

  localparam logic [31:0] LOC_ACQUIRE = 32'd1;
  localparam logic [31:0] LOC_RELEASE = 32'd2;
  localparam logic [31:0] LOC_CLR_EST = 32'd8;
  localparam logic [31:0] REQ_READY   = 32'd1;
  localparam logic [31:0] REQ_IDLE    = 32'd2;
  localparam logic [31:0] DOORBELL    = 32'd1;

  // rev, rsvd, lock, selector, res, crb, fifo, xfer, rsvd, bypass, loccap, ver, type
  localparam logic [31:0] ID_WORD = {8'h00, 4'h0, 1'b0, 2'b01, 2'b00, 1'b1,
                                     1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 4'h1, 4'h1};
  localparam logic [15:0] VENDOR_ID = 16'h1014;

  typedef enum logic [2:0] {
    OP_NONE, OP_LOCCTL, OP_REQ, OP_CANCEL, OP_START
  } ctl_op_e;
endpackage

// File: rtl/crb_buffer.sv
module crb_buffer #(
  parameter int BUF_BYTES = 64,
  parameter int LEN_W     = 16,
  localparam int BOFF_W   = $clog2(BUF_BYTES),
  localparam int IW       = BOFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BOFF_W-1:0] wr_off,
  input  logic [3:0]        wr_len,
  input  logic [63:0]       wr_data,
  input  logic              be_we,
  input  logic [BOFF_W-1:0] be_idx,
  input  logic [7:0]        be_byte,
  input  logic [BOFF_W-1:0] rd_off,
  input  logic [3:0]        rd_len,
  output logic [63:0]       rd_data,
  output logic [LEN_W-1:0]  len_o
);
  logic [BUF_BYTES*8-1:0] flat;
  logic [LEN_W-1:0]       len_q;
  logic                   restart;

  assign restart = wr_en && (wr_off == '0);

  for (genvar i = 0; i < BUF_BYTES; i++) begin : g_byte
    logic [7:0]    byte_q;
    logic [IW-1:0] lane;
    logic          hit;
    always_comb begin
      lane = IW'(i) - IW'(wr_off);
      hit  = wr_en && (IW'(i) >= IW'(wr_off)) && (lane < IW'(wr_len));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                byte_q <= '0;
      else if (be_we && (be_idx == BOFF_W'(i)))  byte_q <= be_byte;
      else if (hit)                              byte_q <= wr_data[{lane[2:0], 3'b000} +: 8];
      else if (restart)                          byte_q <= '0;
    end
    assign flat[i*8 +: 8] = byte_q;
  end

  for (genvar k = 0; k < 8; k++) begin : g_rd
    logic [BOFF_W-1:0] idx;
    assign idx = rd_off + BOFF_W'(k);
    assign rd_data[k*8 +: 8] = (4'(k) < rd_len) ? flat[idx*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= '0;
    else if (restart) len_q <= LEN_W'(wr_len);
    else if (wr_en)   len_q <= len_q + LEN_W'(wr_len);
  end
  assign len_o = len_q;

  p_len_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (len_o == LEN_W'($past(wr_len))));
endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_op_e          op,
  input  logic [31:0]      val,
  input  logic [3:0]       req_loc,
  input  logic             done_valid,
  input  logic [31:0]      done_code,
  input  logic             cmd_ready,
  input  logic [LEN_W-1:0] buf_len,
  output logic             assigned_o,
  output logic             granted_o,
  output logic             seized_o,
  output logic [2:0]       act_loc_o,
  output logic             idle_o,
  output logic             err_o,
  output logic             start_o,
  output logic             cmd_valid_o,
  output logic [LEN_W-1:0] cmd_len_o,
  output logic             cancel_o
);
  logic             assigned_q, granted_q, seized_q, idle_q, err_q, start_q;
  logic             cv_q, cancel_q;
  logic [2:0]       act_q;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       active8;
  logic             accept;

  assign active8 = assigned_q ? {5'b0, act_q} : 8'hFF;
  assign accept  = (op == OP_START) && (val == DOORBELL) && !start_q &&
                   (active8 == {4'h0, req_loc});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      assigned_q <= 1'b0; granted_q <= 1'b0; seized_q <= 1'b0;
      idle_q <= 1'b1; err_q <= 1'b0; start_q <= 1'b0;
      cv_q <= 1'b0; cancel_q <= 1'b0; act_q <= '0; len_q <= '0;
    end else begin
      cancel_q <= (op == OP_CANCEL) && (val == DOORBELL) && start_q;
      if (cv_q && cmd_ready) cv_q <= 1'b0;
      case (op)
        OP_LOCCTL: begin
          if (val == LOC_ACQUIRE) begin
            granted_q <= 1'b1; assigned_q <= 1'b1; seized_q <= 1'b0;
          end else if (val == LOC_RELEASE) begin
            granted_q <= 1'b0; assigned_q <= 1'b0;
          end
        end
        OP_REQ: begin
          if (val == REQ_READY)     idle_q <= 1'b0;
          else if (val == REQ_IDLE) idle_q <= 1'b1;
        end
        default: ;
      endcase
      if (accept) begin
        start_q <= 1'b1;
        cv_q    <= 1'b1;
        len_q   <= buf_len;
      end
      if (done_valid && start_q) begin
        start_q <= 1'b0;
        if (done_code != 32'd0) err_q <= 1'b1;
      end
    end
  end

  assign assigned_o  = assigned_q;
  assign granted_o   = granted_q;
  assign seized_o    = seized_q;
  assign act_loc_o   = act_q;
  assign idle_o      = idle_q;
  assign err_o       = err_q;
  assign start_o     = start_q;
  assign cmd_valid_o = cv_q;
  assign cmd_len_o   = len_q;
  assign cancel_o    = cancel_q;

  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready) |=> (cmd_valid_o && $stable(cmd_len_o)));
  p_cancel_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |-> $past(start_o));
  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && start_o) |=> !start_o);
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(done_valid && (done_code != 32'd0)));
  p_grant_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    granted_o == assigned_o);
endmodule

// File: rtl/crb_regif.sv
module crb_regif
  import crb_pkg::*;
#(
  parameter logic [31:0] WIN_BASE  = 32'hFED4_0000,
  parameter logic [31:0] WIN_SIZE  = 32'h0000_1000,
  parameter int          BUF_BYTES = 64,
  parameter int          LEN_W     = 16,
  localparam int         BOFF_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [15:0]       bus_addr,
  input  logic [3:0]        bus_len,
  input  logic [63:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [63:0]       bus_rdata,
  output logic              bus_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_cancel,
  input  logic              done_valid,
  input  logic [31:0]       done_code,
  input  logic              est_flag,
  input  logic              rsp_we,
  input  logic [BOFF_W-1:0] rsp_idx,
  input  logic [7:0]        rsp_byte
);
  localparam logic [31:0] SIZE_RST = WIN_SIZE - 32'h80;
  localparam logic [31:0] ADDR_RST = WIN_BASE + 32'h80;

  logic        wr, rd, in_regs, buf_fit, len_ok, bad, cfg_we, buf_wr;
  logic [11:0] off12, boff;
  logic [7:0]  roff;
  logic [31:0] wval, reg_val;
  logic [63:0] rd_val, buf_rd;
  ctl_op_e     op;
  logic [31:0] cmd_size_q, cmd_lo_q, cmd_hi_q, rsp_size_q, rsp_addr_q;
  logic        assigned, granted, seized, idle, sts_err, start;
  logic [2:0]  act_loc;
  logic [LEN_W-1:0] buf_len;
  logic        err_q, rvalid_q;
  logic [63:0] rdata_q;

  assign wr      = bus_req && bus_we;
  assign rd      = bus_req && !bus_we;
  assign off12   = bus_addr[11:0];
  assign in_regs = off12 < BUF_BASE;
  assign roff    = off12[7:0];
  assign boff    = off12 - BUF_BASE;
  assign buf_fit = ({1'b0, boff} + 13'(bus_len)) <= 13'(BUF_BYTES);
  assign len_ok  = (bus_len <= 4'd4) || ((roff == OFF_RSP_ADDR) && (bus_len == 4'd8));
  assign wval    = bus_wdata[31:0];

  always_comb begin
    op = OP_NONE; bad = 1'b0; cfg_we = 1'b0; buf_wr = 1'b0;
    if (wr) begin
      if (in_regs) begin
        if (!len_ok) bad = 1'b1;
        else begin
          case (roff)
            OFF_LOC_CTRL: begin
              op  = OP_LOCCTL;
              bad = !((wval == LOC_ACQUIRE) || (wval == LOC_RELEASE) || (wval == LOC_CLR_EST));
            end
            OFF_REQ: begin
              op  = OP_REQ;
              bad = !((wval == REQ_READY) || (wval == REQ_IDLE));
            end
            OFF_CANCEL: op = OP_CANCEL;
            OFF_START:  op = OP_START;
            OFF_CMD_SIZE, OFF_CMD_LO, OFF_CMD_HI, OFF_RSP_SIZE, OFF_RSP_ADDR: cfg_we = 1'b1;
            default: bad = 1'b1;
          endcase
        end
      end else if (buf_fit) buf_wr = 1'b1;
      else bad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_size_q <= SIZE_RST; rsp_size_q <= SIZE_RST;
      cmd_lo_q   <= ADDR_RST; rsp_addr_q <= ADDR_RST;
      cmd_hi_q   <= '0;
    end else if (cfg_we) begin
      case (roff)
        OFF_CMD_SIZE: cmd_size_q <= wval;
        OFF_CMD_LO:   cmd_lo_q   <= wval;
        OFF_CMD_HI:   cmd_hi_q   <= wval;
        OFF_RSP_SIZE: rsp_size_q <= wval;
        default:      rsp_addr_q <= wval;
      endcase
    end
  end

  crb_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op), .val(wval), .req_loc(bus_addr[15:12]),
    .done_valid(done_valid), .done_code(done_code), .cmd_ready(cmd_ready),
    .buf_len(buf_len), .assigned_o(assigned), .granted_o(granted),
    .seized_o(seized), .act_loc_o(act_loc), .idle_o(idle), .err_o(sts_err),
    .start_o(start), .cmd_valid_o(cmd_valid), .cmd_len_o(cmd_len),
    .cancel_o(cmd_cancel)
  );

  crb_buffer #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_wr), .wr_off(boff[BOFF_W-1:0]),
    .wr_len(bus_len), .wr_data(bus_wdata), .be_we(rsp_we), .be_idx(rsp_idx),
    .be_byte(rsp_byte), .rd_off(boff[BOFF_W-1:0]), .rd_len(bus_len),
    .rd_data(buf_rd), .len_o(buf_len)
  );

  always_comb begin
    case (roff)
      OFF_LOC_STATE: reg_val = {24'h0, 1'b1, 2'b00, act_loc, assigned, !est_flag};
      OFF_LOC_STS:   reg_val = {30'h0, seized, granted};
      OFF_ID:        reg_val = ID_WORD;
      OFF_ID2:       reg_val = {16'h0, VENDOR_ID};
      OFF_STS:       reg_val = {30'h0, idle, sts_err};
      OFF_START:     reg_val = {31'h0, start};
      OFF_CMD_SIZE:  reg_val = cmd_size_q;
      OFF_CMD_LO:    reg_val = cmd_lo_q;
      OFF_CMD_HI:    reg_val = cmd_hi_q;
      OFF_RSP_SIZE:  reg_val = rsp_size_q;
      OFF_RSP_ADDR:  reg_val = rsp_addr_q;
      default:       reg_val = 32'h0;
    endcase
    if (in_regs)      rd_val = (bus_len <= 4'd4) ? {32'h0, reg_val} : 64'h0;
    else if (buf_fit) rd_val = buf_rd;
    else              rd_val = 64'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0; rvalid_q <= 1'b0; rdata_q <= '0;
    end else begin
      err_q    <= bad;
      rvalid_q <= rd;
      rdata_q  <= rd ? rd_val : 64'h0;
    end
  end

  assign bus_err    = err_q;
  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;

  p_rvalid_next_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
  p_err_after_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(wr));
endmodule

// File: tb/crb_regif_tb.sv
module crb_regif_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [15:0] bus_addr = 0;
  logic [3:0]  bus_len = 0;
  logic [63:0] bus_wdata = 0;
  logic bus_rvalid, bus_err, cmd_valid, cmd_cancel;
  logic [63:0] bus_rdata;
  logic cmd_ready = 1'b1;
  logic [15:0] cmd_len;
  logic done_valid = 0;
  logic [31:0] done_code = 0;
  logic est_flag = 1'b1;
  logic rsp_we = 0;
  logic [5:0] rsp_idx = 0;
  logic [7:0] rsp_byte = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crb_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
    .cmd_cancel(cmd_cancel), .done_valid(done_valid), .done_code(done_code),
    .est_flag(est_flag), .rsp_we(rsp_we), .rsp_idx(rsp_idx), .rsp_byte(rsp_byte)
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // reference model
  bit m_assigned, m_idle, m_err, m_start;
  logic [15:0] m_len;
  logic [7:0]  m_buf [NB];
  logic [31:0] m_cfg [5];
  bit e_err, e_cv, e_cancel;
  logic [15:0] e_len;
  logic g_err, g_cv, g_cancel, g_rv;
  logic [15:0] g_len;
  logic [63:0] g_rd;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cfg_i(input logic [7:0] o);
    case (o)
      8'h58: return 0; 8'h5C: return 1; 8'h60: return 2; 8'h64: return 3; 8'h68: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [63:0] exp_read(input logic [11:0] off, input logic [3:0] l);
    logic [63:0] r = 0;
    if (off < 12'h80) begin
      if (l > 4) return 0;
      case (off[7:0])
        8'h00: r = {56'h0, 1'b1, 2'b0, 3'b0, m_assigned, ~est_flag};
        8'h0C: r = {62'h0, 1'b0, m_assigned};
        8'h30: r = 64'h0002_5811;
        8'h34: r = 64'h1014;
        8'h44: r = {62'h0, m_idle, m_err};
        8'h4C: r = {63'h0, m_start};
        default: if (cfg_i(off[7:0]) >= 0) r = {32'h0, m_cfg[cfg_i(off[7:0])]};
      endcase
      return r;
    end
    if (int'(off) - 128 + int'(l) > NB) return 0;
    for (int k = 0; k < l; k++) r[k*8 +: 8] = m_buf[int'(off) - 128 + k];
    return r;
  endfunction

  // predicts the effects of a write and updates the model
  task automatic m_write(input logic [15:0] a, input logic [3:0] l, input logic [63:0] d);
    logic [11:0] off = a[11:0];
    logic [31:0] v = d[31:0];
    e_err = 0; e_cv = 0; e_cancel = 0;
    if (off < 12'h80) begin
      if (l > 4 && !(off == 12'h68 && l == 8)) begin e_err = 1; return; end
      case (off[7:0])
        8'h08: if (v == 1) m_assigned = 1; else if (v == 2) m_assigned = 0;
               else if (v != 8) e_err = 1;
        8'h40: if (v == 1) m_idle = 0; else if (v == 2) m_idle = 1; else e_err = 1;
        8'h48: e_cancel = (v == 1) && m_start;
        8'h4C: if (v == 1 && !m_start && m_assigned && a[15:12] == 0) begin
                 m_start = 1; e_cv = 1; e_len = m_len;
               end
        default: if (cfg_i(off[7:0]) >= 0) m_cfg[cfg_i(off[7:0])] = v; else e_err = 1;
      endcase
    end else begin
      int n = int'(off) - 128;
      if (n + int'(l) > NB) begin e_err = 1; return; end
      if (n == 0) begin
        foreach (m_buf[i]) m_buf[i] = 0;
        m_len = 0;
      end
      for (int k = 0; k < l; k++) m_buf[n + k] = d[k*8 +: 8];
      m_len = m_len + 16'(l);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [3:0] l, input logic [63:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_len = l; bus_wdata = d;
    @(negedge clk);
    g_err = bus_err; g_cv = cmd_valid; g_len = cmd_len; g_cancel = cmd_cancel;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [3:0] l);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_len = l;
    @(negedge clk);
    g_rv = bus_rvalid; g_rd = bus_rdata;
    bus_req = 0;
  endtask

  task automatic wr_chk(input logic [15:0] a, input logic [3:0] l, input logic [63:0] d, input string tag);
    m_write(a, l, d);
    bus_wr(a, l, d);
    chk(g_err === e_err, {tag, " err"}, g_err, e_err);
    if (a[11:0] == 12'h04C) begin
      chk(g_cv === e_cv, {tag, " cmd_valid"}, g_cv, e_cv);
      if (e_cv) chk(g_len === e_len, {tag, " cmd_len"}, g_len, e_len);
    end
    if (a[11:0] == 12'h048) chk(g_cancel === e_cancel, {tag, " cancel"}, g_cancel, e_cancel);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [3:0] l, input string tag);
    logic [63:0] e = exp_read(a[11:0], l);
    bus_rd(a, l);
    chk(g_rv === 1'b1, "R13 rvalid", g_rv, 1);
    chk(g_rd === e, tag, g_rd, e);
  endtask

  task automatic done_pulse(input logic [31:0] code);
    @(negedge clk);
    done_valid = 1; done_code = code;
    @(negedge clk);
    done_valid = 0;
    if (m_start) begin
      m_start = 0;
      if (code != 0) m_err = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    m_assigned = 0; m_idle = 1; m_err = 0; m_start = 0; m_len = 0;
    foreach (m_buf[i]) m_buf[i] = 0;
    m_cfg[0] = 32'hF80; m_cfg[1] = 32'hFED4_0080; m_cfg[2] = 0;
    m_cfg[3] = 32'hF80; m_cfg[4] = 32'hFED4_0080;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk(16'h0000, 4, "R1 loc state");
    rd_chk(16'h0044, 4, "R1 ctrl status");
    rd_chk(16'h0030, 4, "R1 id");
    rd_chk(16'h0034, 4, "R1 id2");
    rd_chk(16'h0058, 4, "R1 cmd size");
    rd_chk(16'h005C, 4, "R1 cmd addr lo");
    rd_chk(16'h0060, 4, "R1 cmd addr hi");
    rd_chk(16'h0068, 4, "R1 rsp addr");
    chk(cmd_valid === 0, "R1 cmd_valid idle", cmd_valid, 0);

    // R11 established flag
    est_flag = 0;
    rd_chk(16'h0000, 4, "R11 est low");
    est_flag = 1;

    // R4 start before any locality is assigned
    wr_chk(16'h004C, 4, 1, "R4 no locality");
    // R2 handshake
    wr_chk(16'h0008, 4, 8, "R2 clr-est no effect");
    rd_chk(16'h000C, 4, "R2 status after 8");
    wr_chk(16'h0008, 4, 1, "R2 acquire");
    rd_chk(16'h000C, 4, "R2 granted");
    rd_chk(16'h0000, 4, "R2 assigned");
    wr_chk(16'h0008, 4, 5, "R2 bad value");
    // R3
    wr_chk(16'h0040, 4, 1, "R3 ready");
    rd_chk(16'h0044, 4, "R3 idle clear");
    wr_chk(16'h0040, 4, 7, "R3 bad value");
    rd_chk(16'h0044, 4, "R3 unchanged");

    // R8 restart on byte 0
    wr_chk(16'h0084, 4, 64'hA1B2C3D4, "R8 write at 4");
    wr_chk(16'h0080, 2, 64'h5566, "R8 restart");
    rd_chk(16'h0080, 8, "R8 cleared bytes");
    wr_chk(16'h00BE, 4, 64'h1, "R8 overflow");
    // R4 wrong locality, then right one
    wr_chk(16'h204C, 4, 1, "R4 wrong locality");
    cmd_ready = 0;
    wr_chk(16'h004C, 4, 1, "R4 accepted");
    // R5 hold under back-pressure
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(cmd_valid === 1 && cmd_len === 16'd2, "R5 hold", {cmd_valid, cmd_len}, {1'b1, 16'd2});
    end
    cmd_ready = 1;
    @(negedge clk);
    chk(cmd_valid === 0, "R5 drop after ready", cmd_valid, 0);
    wr_chk(16'h004C, 4, 1, "R4 busy reject");
    wr_chk(16'h0048, 4, 1, "R6 cancel while busy");
    // R9 response byte
    @(negedge clk); rsp_we = 1; rsp_idx = 6'd3; rsp_byte = 8'h9E;
    @(negedge clk); rsp_we = 0; m_buf[3] = 8'h9E;
    rd_chk(16'h0080, 4, "R9 response byte");
    done_pulse(32'h5);
    rd_chk(16'h004C, 4, "R7 start cleared");
    rd_chk(16'h0044, 4, "R7 error set");
    wr_chk(16'h0048, 4, 1, "R6 cancel when idle");
    // R10 widths
    wr_chk(16'h0068, 8, 64'hFFFF_FFFF_1234_5678, "R10 8-byte rsp addr");
    rd_chk(16'h0068, 4, "R10 rsp addr low");
    wr_chk(16'h0058, 8, 64'h77, "R10 wide reject");
    rd_chk(16'h0058, 4, "R10 size unchanged");
    rd_chk(16'h0068, 8, "R10 wide read zero");
    // R12 unmapped and read-only
    wr_chk(16'h0010, 4, 64'h3, "R12 unmapped write");
    rd_chk(16'h0010, 4, "R12 unmapped read");
    wr_chk(16'h0044, 4, 64'h0, "R12 read-only write");
    rd_chk(16'h0044, 4, "R12 status unchanged");
    rd_chk(16'h0040, 4, "R12 req reads zero");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int sel = $urandom % 8;
      logic [31:0] v;
      case (sel)
        0: begin
          case ($urandom % 4) 0: v = 1; 1: v = 2; 2: v = 8; default: v = $urandom % 16; endcase
          wr_chk(16'h0008, 4, 64'(v), "R2 random locctl");
        end
        1: begin
          case ($urandom % 3) 0: v = 1; 1: v = 2; default: v = $urandom % 8; endcase
          wr_chk(16'h0040, 4, 64'(v), "R3 random req");
        end
        2: begin
          logic [3:0] loc = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
          wr_chk({loc, 12'h04C}, 4, 64'(($urandom % 5 == 0) ? 2 : 1), "R4 random start");
        end
        3: begin
          int n = ($urandom % 3 == 0) ? 0 : int'($urandom % 66);
          wr_chk(16'(128 + n), 4'(1 + $urandom % 8), {$urandom, $urandom}, "R8 random buffer write");
        end
        4: rd_chk(16'(128 + $urandom % 66), 4'(1 + $urandom % 8), "R9 random buffer read");
        5: begin
          logic [7:0] o;
          case ($urandom % 5) 0: o = 8'h00; 1: o = 8'h0C; 2: o = 8'h44; 3: o = 8'h4C; default: o = 8'h5C; endcase
          est_flag = 1'($urandom);
          rd_chk({8'h0, o}, 4, "R11 random status read");
        end
        6: done_pulse(($urandom % 2) ? 32'h0 : 32'($urandom));
        default: wr_chk(16'h0048, 4, 64'(($urandom % 4 == 0) ? 3 : 1), "R6 random cancel");
      endcase
    end

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule